// File: doc/BRIEF.md
# Multi-channel PWM generator with shadowed settings

This block is a bank of independent pulse-width generators sharing one simple synchronous register bus. Each channel counts cycles of the input clock against a programmed period, drives its output active during the first part of each period as set by a duty count, and can invert its output. Software writes period, duty and a repeat count into holding registers. These values reach the running counter only when the channel's enable bit is written with 1, so a waveform never changes halfway through a reprogramming sequence.

A channel either runs for ever or stops by itself after a set number of whole periods. When it stops it clears its own enable bit, so software can poll for completion. The number of channels is a parameter: 2, 4 or 8.

Top module: `pwm_bank`

## Requirements
- R1: Each channel owns a 0x20-byte window at byte address 0x20 × channel. Within it the period is at 0x0, the duty at 0x4, the repeat count at 0x8 and the control word at 0xC. Address bits 1:0 are ignored. A read strobe returns the addressed register on `rdata` after the next clock edge, and `rdata` holds its value between reads.
- R2: In the control word, bit 0 enables the channel, bit 1 inverts the output and bit 2 selects continuous running. All other bits ignore writes and read as 0.
- R3: Once enabled with period P > 0 and duty D, the output is active for the first D clock cycles of every P-cycle period, starting from count 0 in the cycle after the enabling write. Active means 1 when bit 1 is 0, and 0 when bit 1 is 1.
- R4: D = 0 gives a constantly inactive output. D ≥ P gives a constantly active output. P = 0 holds the output inactive.
- R5: Writes to period, duty or repeat count leave the running waveform unchanged. Writing the control word with bit 0 set copies the held values into the counter and restarts at count 0, whether or not the channel was already running.
- R6: While bit 0 is 0, the channel's counter stays at 0 and its output equals the polarity bit, which is the inactive level.
- R7: With bit 2 clear, the channel outputs max(N,1) complete periods, where N is the repeat count latched at enable. At the end of the last period bit 0 clears by itself and the output goes inactive.
- R8: Offsets 0x10 to 0x1C of any window, and any window at or beyond the channel count, read as 0. Writes to them change no register.
- R9: Channels run independently: programming one channel does not disturb another channel's waveform.
- R10: After reset every register reads 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW | Read data, registered |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
Every cycle, assertions check four things: the counter of a stopped channel rests at zero, a running counter stays below its period, the active period and duty only change on an enabling write, and a self-clearing of the enable bit happens only at the last cycle of a period with continuous mode off. They also check that the write decode selects at most one channel and never one for a stray address, and that stray reads return 0. Only the bench scenarios can show the actual waveform shapes against period, duty and polarity, the exact stop point after N periods, the deferral of new settings until re-enable, and the independence of channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // register slot inside a channel window, from address bits 3:2
   typedef enum logic [1:0] {
      SEL_PER  = 2'd0,
      SEL_DUTY = 2'd1,
      SEL_REPS = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   localparam int WIN_LSB  = 5;   // 0x20-byte window per channel
   localparam int EN_BIT   = 0;
   localparam int POL_BIT  = 1;
   localparam int KEEP_BIT = 2;

   typedef struct packed {
      logic keep;
      logic pol;
      logic en;
   } ctrl_t;

endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
   import pwm_bank_pkg::*;
#(
   parameter  int NUM_CH = 4,
   parameter  int ADDR_W = 8,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int HI_W   = ADDR_W - WIN_LSB
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output logic              hit,
   output logic [CH_W-1:0]   ch_idx,
   output reg_sel_e          sel,
   output logic [NUM_CH-1:0] wr_ch
);

   logic [HI_W-1:0] win;

   assign win    = addr[ADDR_W-1:WIN_LSB];
   assign hit    = (win < HI_W'(NUM_CH)) && !addr[WIN_LSB-1];
   assign ch_idx = win[CH_W-1:0];
   assign sel    = reg_sel_e'(addr[3:2]);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
      assign wr_ch[g] = wr_en && hit && (ch_idx == CH_W'(g));
   end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
   import pwm_bank_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_per,
   input  logic          wr_duty,
   input  logic          wr_reps,
   input  logic          wr_ctrl,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] per_q,
   output logic [DW-1:0] duty_q,
   output logic [DW-1:0] reps_q,
   output ctrl_t         ctrl_q,
   output logic          pwm_out
);

   logic [DW-1:0] per_act, duty_act, reps_act, cnt, done_cnt;
   logic          load, halt, wrap, last, act;

   assign load = wr_ctrl && wdata[EN_BIT];
   assign halt = wr_ctrl && !wdata[EN_BIT];
   assign wrap = ctrl_q.en && (per_act != '0) && (cnt == per_act - DW'(1));
   assign last = wrap && !ctrl_q.keep && (done_cnt + DW'(1) >= reps_act);

   // held settings, visible to reads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= '0;
         duty_q <= '0;
         reps_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_per)  per_q  <= wdata;
         if (wr_duty) duty_q <= wdata;
         if (wr_reps) reps_q <= wdata;
         if (wr_ctrl) begin
            ctrl_q.en   <= wdata[EN_BIT];
            ctrl_q.pol  <= wdata[POL_BIT];
            ctrl_q.keep <= wdata[KEEP_BIT];
         end else if (last) begin
            ctrl_q.en <= 1'b0;
         end
      end
   end

   // running copy and counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_act  <= '0;
         duty_act <= '0;
         reps_act <= '0;
         cnt      <= '0;
         done_cnt <= '0;
      end else if (load) begin
         per_act  <= per_q;
         duty_act <= duty_q;
         reps_act <= reps_q;
         cnt      <= '0;
         done_cnt <= '0;
      end else if (!ctrl_q.en || halt || last) begin
         cnt      <= '0;
         done_cnt <= '0;
      end else if (wrap) begin
         cnt <= '0;
         if (!ctrl_q.keep) done_cnt <= done_cnt + DW'(1);
      end else if (per_act != '0) begin
         cnt <= cnt + DW'(1);
      end
   end

   assign act     = ctrl_q.en && (per_act != '0) && (cnt < duty_act);
   assign pwm_out = act ^ ctrl_q.pol;

   // R6
   idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |-> cnt == '0);
   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && per_act != '0) |-> cnt < per_act);
   // R5
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(per_act) && $stable(duty_act)));
   // R7
   self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_q.en) && !$past(wr_ctrl)) |-> ($past(wrap) && !$past(ctrl_q.keep)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              rd_en,
   output logic [DW-1:0]     rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int CH_W = $clog2(NUM_CH);

   if (NUM_CH != 2 && NUM_CH != 4 && NUM_CH != 8) begin : g_bad_ch
      $error("pwm_bank: NUM_CH must be 2, 4 or 8");
   end
   if (ADDR_W < CH_W + WIN_LSB + 1) begin : g_bad_aw
      $error("pwm_bank: ADDR_W too narrow for channel windows");
   end
   if (DW < 3) begin : g_bad_dw
      $error("pwm_bank: DW must hold the control bits");
   end

   logic              hit;
   logic [CH_W-1:0]   ch_idx;
   reg_sel_e          sel;
   logic [NUM_CH-1:0] wr_ch;

   pwm_bank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
      .addr   (addr),
      .wr_en  (wr_en),
      .hit    (hit),
      .ch_idx (ch_idx),
      .sel    (sel),
      .wr_ch  (wr_ch)
   );

   logic [DW-1:0] per_a  [NUM_CH];
   logic [DW-1:0] duty_a [NUM_CH];
   logic [DW-1:0] reps_a [NUM_CH];
   ctrl_t         ctrl_a [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwm_bank_chan #(.DW(DW)) chan_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_per  (wr_ch[g] && sel == SEL_PER),
         .wr_duty (wr_ch[g] && sel == SEL_DUTY),
         .wr_reps (wr_ch[g] && sel == SEL_REPS),
         .wr_ctrl (wr_ch[g] && sel == SEL_CTRL),
         .wdata   (wdata),
         .per_q   (per_a[g]),
         .duty_q  (duty_a[g]),
         .reps_q  (reps_a[g]),
         .ctrl_q  (ctrl_a[g]),
         .pwm_out (pwm_out[g])
      );
   end

   logic [DW-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (hit) begin
         case (sel)
            SEL_PER:  rd_word = per_a[ch_idx];
            SEL_DUTY: rd_word = duty_a[ch_idx];
            SEL_REPS: rd_word = reps_a[ch_idx];
            SEL_CTRL: rd_word = DW'(ctrl_a[ch_idx]);
            default:  rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end

   // R8
   stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> wr_ch == '0);
   // R9
   one_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_ch));
   // R8
   stray_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> rdata == '0);
   // R1
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;

   localparam int NCH = 4;
   localparam int AW  = 8;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rdata;
   logic [NCH-1:0] pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .pwm_out(pwm_out)
   );

   function automatic logic [AW-1:0] ra(int ch, int off);
      return AW'(ch * 32 + off);
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write
   task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic exp_out(int p, int d, int pol, int idx);
      logic a;
      a = (p != 0) && ((idx % (p == 0 ? 1 : p)) < d);
      return a ^ pol[0];
   endfunction

   task automatic chk_wave(string req, int ch, int p, int d, int pol, int start, int n);
      for (int i = 0; i < n; i++) begin
         check(req, DW'(pwm_out[ch]), DW'(exp_out(p, d, pol, start + i)));
         @(negedge clk);
      end
   endtask

   logic [DW-1:0] v;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check("R10 outputs", DW'(pwm_out), '0);
      for (int c = 0; c < NCH; c++) begin
         for (int o = 0; o < 16; o += 4) begin
            bus_rd(ra(c, o), v);
            check("R10 regs", v, '0);
         end
      end

      // R1 readback of each slot; R2 undefined control bits
      bus_wr(ra(1, 0), 32'hDEAD_BEEF);
      bus_wr(ra(1, 4), 32'h1234_5678);
      bus_wr(ra(1, 8), 32'h0000_00A5);
      bus_wr(ra(1, 12), 32'hFFFF_FFFA);
      bus_rd(ra(1, 0), v); check("R1 period", v, 32'hDEAD_BEEF);
      bus_rd(ra(1, 4), v); check("R1 duty", v, 32'h1234_5678);
      bus_rd(ra(1, 8), v); check("R1 repeat", v, 32'h0000_00A5);
      bus_rd(ra(1, 12) | AW'(3), v); check("R2 ctrl bits", v, 32'h2);
      check("R6 inverted idle", DW'(pwm_out[1]), 1);
      bus_wr(ra(1, 12), 32'h0);

      // R8 stray addresses
      bus_wr(ra(0, 0), 32'h55);
      bus_wr(ra(4, 0), 32'hFFFF);
      bus_wr(ra(0, 16), 32'hFFFF);
      bus_wr(ra(0, 28), 32'hFFFF);
      bus_wr(ra(7, 12), 32'h7);
      bus_rd(ra(4, 0), v); check("R8 beyond channels", v, '0);
      bus_rd(ra(0, 16), v); check("R8 gap slot", v, '0);
      bus_rd(ra(0, 28), v); check("R8 gap slot", v, '0);
      bus_rd(ra(0, 0), v); check("R8 no side effect", v, 32'h55);
      check("R8 outputs idle", DW'(pwm_out), '0);

      // R3 R4 R6 sweep of period, duty and polarity on channel 0
      for (int p = 0; p <= 5; p++) begin
         for (int d = 0; d <= 6; d++) begin
            for (int pol = 0; pol < 2; pol++) begin
               bus_wr(ra(0, 0), DW'(p));
               bus_wr(ra(0, 4), DW'(d));
               bus_wr(ra(0, 12), DW'(32'h5 | (pol << 1)));
               chk_wave("R3 R4 wave", 0, p, d, pol, 0, (p == 0) ? 6 : 2 * p + 1);
               bus_wr(ra(0, 12), DW'(pol << 1));
               repeat (2) begin
                  check("R6 disabled level", DW'(pwm_out[0]), DW'(pol));
                  @(negedge clk);
               end
            end
         end
      end

      // R5 shadowing and re-enable
      bus_wr(ra(1, 0), 32'd4);
      bus_wr(ra(1, 4), 32'd1);
      bus_wr(ra(1, 12), 32'h5);
      chk_wave("R5 before", 1, 4, 1, 0, 0, 8);
      bus_wr(ra(1, 0), 32'd6);
      bus_wr(ra(1, 4), 32'd3);
      chk_wave("R5 held", 1, 4, 1, 0, 10, 8);
      bus_wr(ra(1, 12), 32'h5);
      chk_wave("R5 reloaded", 1, 6, 3, 0, 0, 12);
      bus_wr(ra(1, 12), 32'h0);

      // R7 self stop after N periods
      bus_wr(ra(2, 0), 32'd3);
      bus_wr(ra(2, 4), 32'd2);
      bus_wr(ra(2, 8), 32'd3);
      bus_wr(ra(2, 12), 32'h1);
      chk_wave("R7 periods", 2, 3, 2, 0, 0, 9);
      check("R7 stopped", DW'(pwm_out[2]), 0);
      bus_rd(ra(2, 12), v); check("R7 enable cleared", v, '0);
      chk_wave("R7 stays idle", 2, 0, 0, 0, 0, 4);
      // R7 with count 0 acts as one period, inverted
      bus_wr(ra(2, 8), 32'd0);
      bus_wr(ra(2, 12), 32'h3);
      chk_wave("R7 single period", 2, 3, 2, 1, 0, 3);
      check("R7 single stop", DW'(pwm_out[2]), 1);
      bus_rd(ra(2, 12), v); check("R7 single cleared", v, 32'h2);
      bus_wr(ra(2, 12), 32'h0);

      // R9 two channels at once
      bus_wr(ra(3, 0), 32'd5);
      bus_wr(ra(3, 4), 32'd2);
      bus_wr(ra(3, 12), 32'h5);
      bus_wr(ra(0, 0), 32'd3);
      bus_wr(ra(0, 4), 32'd1);
      bus_wr(ra(0, 12), 32'h7);
      for (int i = 0; i < 15; i++) begin
         check("R9 ch3", DW'(pwm_out[3]), DW'(exp_out(5, 2, 0, i + 3)));
         check("R9 ch0", DW'(pwm_out[0]), DW'(exp_out(3, 1, 1, i)));
         @(negedge clk);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule